// File: doc/BRIEF.md
# Two-Wire Serial Slave Byte Front End

This block sits between a two-wire serial bus and a register access engine. It watches the bus for start and stop conditions and shifts in the address byte. When the upper seven bits match its own device address, it acknowledges. It then hands every received byte to the engine through a byte-strobe interface, or it sends the bytes the engine supplies back to the bus master. The device address is the fixed prefix `01110` followed by two pin-strapped bits. The block is only ever a slave. It never drives SCL and never starts a transfer.

On a write, the first two bytes after the address are tagged as the high and low halves of the register subaddress. Every later byte is tagged as data, so the engine can auto-increment through a burst. On a read, the block asks the engine for each byte just before that byte is needed. It stops asking once the master answers a byte with NACK. A stop condition ends the burst and is reported to the engine as a single-cycle pulse. A repeated start goes back into address reception without ending the burst, which supports the usual pattern of writing a subaddress and then reading from it. SDA is modelled as a plain input plus an open-drain pull-low enable. Both bus lines pass through a synchronizer before the block uses them.

Top module: `twi_slave_fe`

## Requirements
- R1: After reset `sda_pull_o` is 0 and no strobe (`wr_strb_o`, `rd_req_o`, `burst_end_o`) is pulsed.
- R2: After a start (SDA falling while SCL is high), the first eight bits are shifted in MSB first. When bits 7..1 equal `{5'b01110, strap_i[1], strap_i[0]}`, the slave pulls SDA low during the ninth clock. Bit 0 is the direction bit: 1 means read, 0 means write.
- R3: On an address mismatch the slave does not acknowledge. It then pulses no strobe until the next start, and the stop that follows produces no `burst_end_o`.
- R4: Changing `strap_i` changes which address is acknowledged. The address for the old strap value is then refused.
- R5: In a write, each received byte is acknowledged and presented on `wr_data_o` with a one-cycle `wr_strb_o`. `wr_kind_o` is 0 for the first byte (subaddress high), 1 for the second byte (subaddress low) and 2 for every later byte (data).
- R6: In a read, `rd_req_o` pulses once when the address is acknowledged. The byte present on `rd_data_i` during that pulse is sent MSB first, one bit per clock, with the slave pulling SDA low for 0 bits.
- R7: Each master ACK (SDA low in the ninth clock of a read byte) causes one further `rd_req_o` and the next byte is sent. After a master NACK the slave releases SDA, issues no further `rd_req_o` and sends nothing more until the next start.
- R8: A stop condition (SDA rising while SCL is high) after an acknowledged address pulses `burst_end_o` once, releases SDA and returns the slave to idle.
- R9: A repeated start re-enters address reception, restarts the subaddress/data byte tagging and does not pulse `burst_end_o`.
- R10: `sda_pull_o` changes value only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Pin-strapped low address bits (bit 1 first on the wire) |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_strb_o | output | 1 | One-cycle pulse: a received byte is on wr_data_o |
| wr_kind_o | output | 2 | Tag of the received byte: 0 subaddress high, 1 subaddress low, 2 data |
| wr_data_o | output | 8 | Received byte |
| rd_req_o | output | 1 | One-cycle pulse: engine must present the next read byte on rd_data_i during this cycle |
| rd_data_i | input | 8 | Read byte supplied by the engine |
| burst_end_o | output | 1 | One-cycle pulse on a stop that ends an acknowledged transfer |

## Verification
The bench addresses the slave with the correct address and with addresses whose strap bits are wrong. A design that compared fewer bits, or ignored the straps, would acknowledge the wrong address, or would go on to strobe the bytes of another device's transfer. In a read, the master ACKs two bytes, NACKs the third and then keeps clocking. A slave that miscounted the ninth clock would corrupt the bytes it sends, and one that ignored the NACK would request a fourth byte and pull SDA low in the extra clocks. A write followed by a repeated start checks that the byte tags restart and that `burst_end_o` is held back until the real stop. A design that treated the repeated start as a stop would pulse `burst_end_o` twice.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } fe_state_e;

    typedef enum logic [1:0] {
        KIND_SUB_HI = 2'd0,
        KIND_SUB_LO = 2'd1,
        KIND_DATA   = 2'd2
    } byte_kind_e;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef struct packed {
        fe_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  rx_sh;
        logic [BYTE_W-1:0]  tx_sh;
        logic               pull;
        byte_kind_e         kind;
        logic               matched;
        logic               rnw;
        logic               nack;
        logic               wr_strb;
        logic [BYTE_W-1:0]  wr_data;
        byte_kind_e         wr_kind;
        logic               rd_req;
        logic               burst_end;
    } fe_regs_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int CHAIN = (STAGES < 2) ? 2 : STAGES;

    typedef struct packed {
        logic [CHAIN-1:0] scl_ff;
        logic [CHAIN-1:0] sda_ff;
        logic             scl_prev;
        logic             sda_prev;
    } sync_regs_t;

    sync_regs_t s_q, s_d;

    always_comb begin
        s_d          = s_q;
        s_d.scl_ff   = {s_q.scl_ff[CHAIN-2:0], scl_i};
        s_d.sda_ff   = {s_q.sda_ff[CHAIN-2:0], sda_i};
        s_d.scl_prev = s_q.scl_ff[CHAIN-1];
        s_d.sda_prev = s_q.sda_ff[CHAIN-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    logic scl_now, sda_now;
    assign scl_now = s_q.scl_ff[CHAIN-1];
    assign sda_now = s_q.sda_ff[CHAIN-1];

    assign scl_o      = scl_now;
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~s_q.scl_prev;
    assign scl_fall_o = ~scl_now & s_q.scl_prev;
    // Conditions only count while the clock line stayed high across the edge
    assign start_o    = scl_now & s_q.scl_prev & ~sda_now & s_q.sda_prev;
    assign stop_o     = scl_now & s_q.scl_prev & sda_now & ~s_q.sda_prev;

endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match #(
    parameter int          PREFIX_W = 5,
    parameter int          STRAP_W  = 2,
    parameter logic [PREFIX_W-1:0] PREFIX = 5'b01110
) (
    input  logic [PREFIX_W+STRAP_W:0] addr_byte_i,
    input  logic [STRAP_W-1:0]        strap_i,
    output logic                      hit_o,
    output logic                      rnw_o
);
    localparam int ID_W = PREFIX_W + STRAP_W;

    logic [ID_W-1:0] own_id;
    logic [ID_W-1:0] diff;

    assign own_id = {PREFIX, strap_i};

    for (genvar i = 0; i < ID_W; i++) begin : g_cmp
        assign diff[i] = addr_byte_i[i+1] ^ own_id[i];
    end

    assign hit_o = (diff == '0);
    assign rnw_o = addr_byte_i[0];

endmodule

// File: rtl/twi_byte_fsm.sv
module twi_byte_fsm
    import twi_pkg::*;
#(
    parameter int STRAP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic               sda_pull_o,
    output logic               wr_strb_o,
    output logic [1:0]         wr_kind_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               rd_req_o,
    output logic               burst_end_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    fe_regs_t q, d;
    logic     addr_hit;
    logic     addr_rnw;

    twi_addr_match #(
        .PREFIX_W (BYTE_W - 1 - STRAP_W),
        .STRAP_W  (STRAP_W),
        .PREFIX   ((BYTE_W - 1 - STRAP_W)'(5'b01110))
    ) u_match (
        .addr_byte_i (q.rx_sh),
        .strap_i     (strap_i),
        .hit_o       (addr_hit),
        .rnw_o       (addr_rnw)
    );

    function automatic byte_kind_e next_kind(input byte_kind_e k);
        case (k)
            KIND_SUB_HI: return KIND_SUB_LO;
            default:     return KIND_DATA;
        endcase
    endfunction

    always_comb begin
        d           = q;
        d.wr_strb   = 1'b0;
        d.rd_req    = 1'b0;
        d.burst_end = 1'b0;

        // Engine answers a request during the request cycle
        if (q.rd_req) begin
            d.tx_sh = rd_data_i;
        end

        if (stop_det) begin
            d.st      = ST_IDLE;
            d.pull    = 1'b0;
            d.matched = 1'b0;
            d.burst_end = q.matched;
        end else if (start_det) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.pull = 1'b0;
            d.kind = KIND_SUB_HI;
        end else begin
            case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.rx_sh = {q.rx_sh[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        if (addr_hit) begin
                            d.st      = ST_ADDR_ACK;
                            d.pull    = 1'b1;
                            d.matched = 1'b1;
                            d.rnw     = addr_rnw;
                            d.rd_req  = addr_rnw;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rnw) begin
                            d.st   = ST_TX;
                            d.pull = ~q.tx_sh[BYTE_W-1];
                            d.nack = 1'b0;
                        end else begin
                            d.st   = ST_RX;
                            d.pull = 1'b0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        d.rx_sh = {q.rx_sh[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        d.wr_strb = 1'b1;
                        d.wr_data = q.rx_sh;
                        d.wr_kind = q.kind;
                        d.kind    = next_kind(q.kind);
                        d.pull    = 1'b1;
                        d.st      = ST_RX_ACK;
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.pull = 1'b0;
                        d.cnt  = '0;
                        d.st   = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.pull = 1'b0;
                            d.st   = ST_TX_ACK;
                        end else begin
                            d.tx_sh = {q.tx_sh[BYTE_W-2:0], 1'b0};
                            d.pull  = ~q.tx_sh[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.nack   = sda_s;
                        d.rd_req = ~sda_s;
                    end else if (scl_fall) begin
                        d.cnt = '0;
                        if (q.nack) begin
                            d.st   = ST_IGNORE;
                            d.pull = 1'b0;
                        end else begin
                            d.st   = ST_TX;
                            d.pull = ~q.tx_sh[BYTE_W-1];
                        end
                    end
                end
                default: begin
                    d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.kind    <= KIND_SUB_HI;
            q.wr_kind <= KIND_SUB_HI;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o  = q.pull;
    assign wr_strb_o   = q.wr_strb;
    assign wr_kind_o   = q.wr_kind;
    assign wr_data_o   = q.wr_data;
    assign rd_req_o    = q.rd_req;
    assign burst_end_o = q.burst_end;

endmodule

// File: rtl/twi_slave_fe.sv
module twi_slave_fe #(
    parameter int SYNC_STAGES = 2,
    parameter int STRAP_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic               wr_strb_o,
    output logic [1:0]         wr_kind_o,
    output logic [7:0]         wr_data_o,
    output logic               rd_req_o,
    input  logic [7:0]         rd_data_i,
    output logic               burst_end_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    logic scl_unused;
    assign scl_unused = scl_s;

    twi_byte_fsm #(
        .STRAP_W (STRAP_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .strap_i     (strap_i),
        .rd_data_i   (rd_data_i),
        .sda_pull_o  (sda_pull_o),
        .wr_strb_o   (wr_strb_o),
        .wr_kind_o   (wr_kind_o),
        .wr_data_o   (wr_data_o),
        .rd_req_o    (rd_req_o),
        .burst_end_o (burst_end_o)
    );

endmodule

// File: rtl/twi_slave_fe_checker.sv
module twi_slave_fe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_pull_o,
    input logic       wr_strb_o,
    input logic [1:0] wr_kind_o,
    input logic       rd_req_o,
    input logic       burst_end_o
);
    // R1: quiet outputs while reset is applied
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!sda_pull_o && !wr_strb_o && !rd_req_o && !burst_end_o);
        end
    end

    // R10: the pull-low enable only moves while the clock line is low
    a_r10_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> !scl_i);

    // R5: byte strobes come out while the clock line is low and carry a legal tag
    a_r5_strobe_legal: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strb_o |-> (!scl_i && wr_kind_o != 2'd3));

    // R5 / R6 / R8: at most one engine event per cycle, each a single-cycle pulse
    a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strb_o, rd_req_o, burst_end_o}));

    a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R8: the burst ends with the data line released
    a_r8_end_released: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end_o |-> !sda_pull_o);

endmodule

bind twi_slave_fe twi_slave_fe_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_pull_o  (sda_pull_o),
    .wr_strb_o   (wr_strb_o),
    .wr_kind_o   (wr_kind_o),
    .rd_req_o    (rd_req_o),
    .burst_end_o (burst_end_o)
);

// File: tb/tb_twi_slave_fe.sv
`timescale 1ns/1ps
module tb_twi_slave_fe;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_pull, wr_strb, rd_req, burst_end;
    logic [1:0] wr_kind;
    logic [7:0] wr_data, rd_data;
    logic       sda_line;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    int n_wr = 0, n_rd = 0, n_end = 0;
    logic [7:0] wr_log_d [16];
    logic [1:0] wr_log_k [16];
    logic [7:0] rd_mem [8];
    int  rd_ptr = 0;
    bit  rd_pend = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rd_data  = rd_mem[rd_ptr % 8];

    twi_slave_fe dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
        .sda_pull_o(sda_pull), .wr_strb_o(wr_strb), .wr_kind_o(wr_kind),
        .wr_data_o(wr_data), .rd_req_o(rd_req), .rd_data_i(rd_data),
        .burst_end_o(burst_end)
    );

    // Port monitor and read-data engine model, sampled away from the active edge
    always @(negedge clk) begin
        if (rd_pend) rd_ptr <= rd_ptr + 1;
        rd_pend <= rd_req;
        if (wr_strb && n_wr < 16) begin
            wr_log_d[n_wr] <= wr_data;
            wr_log_k[n_wr] <= wr_kind;
        end
        if (wr_strb) n_wr <= n_wr + 1;
        if (rd_req) n_rd <= n_rd + 1;
        if (burst_end) n_end <= n_end + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_clk(Q); scl = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q); scl = 1'b0;
    endtask

    task automatic bus_stop;
        wait_clk(Q); sda_m = 1'b0; wait_clk(Q); scl = 1'b1;
        wait_clk(Q); sda_m = 1'b1; wait_clk(2*Q);
    endtask

    task automatic put_bit(input logic b);
        wait_clk(Q); sda_m = b; wait_clk(Q); scl = 1'b1; wait_clk(2*Q); scl = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        wait_clk(Q); sda_m = 1'b1; wait_clk(Q); scl = 1'b1;
        wait_clk(Q); b = sda_line; wait_clk(Q); scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(master_ack);
    endtask

    task automatic t_reset;
        check("R1 pull after reset", sda_pull, 0);
        check("R1 strobes after reset", n_wr + n_rd + n_end, 0);
    endtask

    task automatic t_write;
        logic ack;
        logic [7:0] bytes [4] = '{8'h40, 8'h0A, 8'h5C, 8'h33};
        strap = 2'b10;
        bus_start;
        put_byte({5'b01110, 2'b10, 1'b0}, ack);
        check("R2 address ack", ack, 0);
        for (int i = 0; i < 4; i++) begin
            put_byte(bytes[i], ack);
            check("R5 byte ack", ack, 0);
        end
        bus_stop;
        check("R5 strobe count", n_wr, 4);
        check("R5 kind sub hi", wr_log_k[0], 0);
        check("R5 kind sub lo", wr_log_k[1], 1);
        check("R5 kind data", wr_log_k[2], 2);
        check("R5 kind data 2", wr_log_k[3], 2);
        for (int i = 0; i < 4; i++) check("R5 data", wr_log_d[i], bytes[i]);
        check("R8 burst end count", n_end, 1);
        check("R8 released", sda_pull, 0);
    endtask

    task automatic t_mismatch;
        logic ack;
        int wr0, end0;
        wr0 = n_wr; end0 = n_end;
        strap = 2'b10;
        bus_start;
        put_byte({5'b01110, 2'b01, 1'b0}, ack);
        check("R3 no address ack", ack, 1);
        put_byte(8'h12, ack);
        check("R3 no byte ack", ack, 1);
        bus_stop;
        check("R3 no strobe", n_wr - wr0, 0);
        check("R3 no burst end", n_end - end0, 0);
        bus_start;
        put_byte({5'b11110, 2'b10, 1'b0}, ack);
        check("R3 prefix mismatch", ack, 1);
        bus_stop;
    endtask

    task automatic t_strap;
        logic ack;
        strap = 2'b01;
        wait_clk(4);
        bus_start;
        put_byte({5'b01110, 2'b01, 1'b0}, ack);
        check("R4 new strap acked", ack, 0);
        bus_stop;
        bus_start;
        put_byte({5'b01110, 2'b10, 1'b0}, ack);
        check("R4 old strap refused", ack, 1);
        bus_stop;
    endtask

    task automatic t_read;
        logic ack;
        logic [7:0] v;
        int wr0, rd0, end0;
        rd_mem[0] = 8'hA5; rd_mem[1] = 8'h3C; rd_mem[2] = 8'h81; rd_mem[3] = 8'h00;
        for (int i = 4; i < 8; i++) rd_mem[i] = 8'h00;
        wait_clk(2);
        rd_ptr = 0;
        strap = 2'b01;
        wr0 = n_wr; end0 = n_end;
        bus_start;
        put_byte({5'b01110, 2'b01, 1'b0}, ack);
        put_byte(8'h40, ack);
        put_byte(8'h1F, ack);
        check("R9 pre repeated start strobes", n_wr - wr0, 2);
        rd0 = n_rd;
        bus_start;
        check("R9 no burst end on repeated start", n_end - end0, 0);
        put_byte({5'b01110, 2'b01, 1'b1}, ack);
        check("R9 read address ack", ack, 0);
        check("R6 first request", n_rd - rd0, 1);
        get_byte(1'b0, v);
        check("R6 byte 0", v, 8'hA5);
        get_byte(1'b0, v);
        check("R7 byte 1", v, 8'h3C);
        get_byte(1'b1, v);
        check("R7 byte 2", v, 8'h81);
        check("R7 request count", n_rd - rd0, 3);
        get_byte(1'b1, v);
        check("R7 released after nack", v, 8'hFF);
        check("R7 no request after nack", n_rd - rd0, 3);
        bus_stop;
        check("R8 read burst end", n_end - end0, 1);
        bus_start;
        put_byte({5'b01110, 2'b01, 1'b0}, ack);
        put_byte(8'h77, ack);
        check("R9 tags restart", wr_log_k[(n_wr - 1) % 16], 0);
        bus_stop;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rd_mem[i] = 8'h00;
        wait_clk(5);
        t_reset;
        rst_n = 1'b1;
        wait_clk(5);
        t_reset;
        t_write;
        t_mismatch;
        t_strap;
        t_read;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule